// File: doc/BRIEF.md
# Sparse-Space Address and Byte-Enable Decoder

This block sits between a 64-bit processor address bus and a 32-bit PCI master. A processor reaches narrow PCI locations through a sparse window: the low processor address bits do not select bytes. Bits 4:3 carry a transfer length code and bits 6:5 carry a byte offset inside the longword. The decoder takes these two codes apart. It produces active-low PCI byte enables and a transfer size, builds a longword-aligned PCI address, and picks one of four host bridges from a module-id field.

For memory space, the top three PCI address bits do not come from the processor address. They come from a small extension register, which software loads through a one-cycle write port. Any length/offset pair outside the supported set is rejected, as is a module id that no bridge answers to. A rejected access raises a one-cycle flag and issues no PCI request. Every decode takes exactly one clock: the request is sampled on one edge and the result is presented after it.

Top module: `sparse_xlate`

## Requirements
- R1: While reset is active and in the first cycle after it, `pci_valid` and `bad_access` are low. The extension register resets to 000, so the first memory access carries PCI bits 31:29 = 000.
- R2: A byte transfer (length code 00) is legal at every offset. Offsets 0, 1, 2 and 3 give `pci_be_n` = 1110, 1101, 1011 and 0111 (bit n low means lane n takes part).
- R3: A word transfer (length code 01) is legal only at offset 0, giving 1100, and at offset 2, giving 0011. Offsets 1 and 3 are illegal.
- R4: A tribyte transfer (length code 10) is legal only at offset 0, giving 1000, and at offset 1, giving 0001. Offsets 2 and 3 are illegal.
- R5: A longword transfer (length code 11) is legal only at offset code 2 and gives 0000. Every other offset is illegal.
- R6: An illegal access raises `bad_access` for exactly one cycle and keeps `pci_valid` low in that cycle. The two outputs are never high together.
- R7: On a legal access, `pci_size` equals the length code: 0 byte, 1 word, 2 tribyte, 3 longword.
- R8: PCI address bits 25:2 equal processor address bits 30:7, and PCI address bits 1:0 are 00.
- R9: When processor bit 31 is 0 (memory space), `pci_is_io` is 0. PCI bits 31:29 equal the extension register and PCI bits 28:26 are 000.
- R10: When processor bit 31 is 1 (I/O space), `pci_is_io` is 1 and PCI bits 31:26 are all zero, whatever the extension register holds.
- R11: The module id in processor bits 35:33 selects the bridge: ids 4, 5, 6 and 7 give `pci_bridge` 0, 1, 2 and 3. Ids 0 to 3 make the access illegal.
- R12: A write to the extension register is seen by accesses presented in later cycles. An access presented in the same cycle as the write still uses the old value.
- R13: Each cycle with `req_valid` high produces exactly one result cycle, on the following clock: either `pci_valid` or `bad_access`. A cycle without a request produces neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A processor access is presented this cycle |
| req_addr | input | 64 | Sparse-encoded processor address |
| ext_wr_en | input | 1 | Load the memory address extension register |
| ext_wr_data | input | 3 | New extension value (PCI bits 31:29) |
| pci_valid | output | 1 | Decoded PCI request is present |
| pci_addr | output | 32 | Longword-aligned PCI address |
| pci_be_n | output | 4 | Active-low byte enables |
| pci_size | output | 2 | Transfer size code |
| pci_bridge | output | 2 | Selected host bridge |
| pci_is_io | output | 1 | Request targets I/O space |
| bad_access | output | 1 | One-cycle reject of an illegal access |

## Verification
The decoder is tried with all sixteen length/offset pairs. This separates the legal cells, each checked for its own enable pattern, from the illegal ones, which must raise only the reject flag. Address fields are driven with all zeros, all ones and alternating bits, which shows that the offset bits are shifted correctly and none of them reaches a neighbouring field. The eight module ids separate the bridge mapping from the id rejects. Memory and I/O accesses are interleaved with extension writes, and one write lands in the same cycle as an access, to show when the new upper bits apply and that I/O space ignores them.

// File: rtl/sparse_xlate_pkg.sv
package sparse_xlate_pkg;

  typedef enum logic [1:0] {
    XFER_BYTE = 2'd0,
    XFER_WORD = 2'd1,
    XFER_TRI  = 2'd2,
    XFER_LONG = 2'd3
  } xfer_len_e;

  typedef struct packed {
    logic       legal;
    logic [3:0] be_n;
  } lane_t;

  // Length code and byte offset -> legality and active-low lane enables.
  function automatic lane_t lane_decode(input logic [1:0] len, input logic [1:0] off);
    lane_t r;
    r.legal = 1'b0;
    r.be_n  = 4'hF;
    unique case (xfer_len_e'(len))
      XFER_BYTE: begin
        r.legal = 1'b1;
        r.be_n  = ~(4'b0001 << off);
      end
      XFER_WORD: begin
        if (off == 2'd0) begin r.legal = 1'b1; r.be_n = 4'b1100; end
        if (off == 2'd2) begin r.legal = 1'b1; r.be_n = 4'b0011; end
      end
      XFER_TRI: begin
        if (off == 2'd0) begin r.legal = 1'b1; r.be_n = 4'b1000; end
        if (off == 2'd1) begin r.legal = 1'b1; r.be_n = 4'b0001; end
      end
      XFER_LONG: begin
        if (off == 2'd2) begin r.legal = 1'b1; r.be_n = 4'b0000; end
      end
      default: r.legal = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sx_ext_reg.sv
module sx_ext_reg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= wr_data;
  end
endmodule

// File: rtl/sx_lane_decode.sv
module sx_lane_decode
  import sparse_xlate_pkg::*;
(
  input  logic [1:0] len,
  input  logic [1:0] off,
  output logic       legal,
  output logic [3:0] be_n
);
  lane_t res;
  always_comb res = lane_decode(len, off);
  assign legal = res.legal;
  assign be_n  = res.be_n;
endmodule

// File: rtl/sx_bridge_sel.sv
module sx_bridge_sel #(
  parameter int MID_W    = 3,
  parameter int N_BRIDGE = 4,
  parameter int MID_BASE = 4,
  localparam int BR_W    = $clog2(N_BRIDGE)
) (
  input  logic [MID_W-1:0] mid,
  output logic             hit,
  output logic [BR_W-1:0]  idx
);
  logic [N_BRIDGE-1:0] hit_vec;

  for (genvar b = 0; b < N_BRIDGE; b++) begin : g_br
    assign hit_vec[b] = (mid == MID_W'(MID_BASE + b));
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < N_BRIDGE; i++) begin
      if (hit_vec[i]) idx = BR_W'(i);
    end
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/sparse_xlate.sv
module sparse_xlate
  import sparse_xlate_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int PCI_W    = 32,
  parameter int EXT_W    = 3,
  parameter int OFS_LSB  = 7,
  parameter int OFS_W    = 24,
  parameter int IO_BIT   = 31,
  parameter int MID_LSB  = 33,
  parameter int MID_W    = 3,
  parameter int N_BRIDGE = 4,
  parameter int MID_BASE = 4,
  localparam int BR_W    = $clog2(N_BRIDGE),
  localparam int PAD_W   = PCI_W - EXT_W - OFS_W - 2,
  localparam int IOPAD_W = PCI_W - OFS_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              ext_wr_en,
  input  logic [EXT_W-1:0]  ext_wr_data,
  output logic              pci_valid,
  output logic [PCI_W-1:0]  pci_addr,
  output logic [3:0]        pci_be_n,
  output logic [1:0]        pci_size,
  output logic [BR_W-1:0]   pci_bridge,
  output logic              pci_is_io,
  output logic              bad_access
);

  // Named internal events, also watched by the bound checker.
  logic [EXT_W-1:0] ext_q;
  logic             dec_legal;
  logic [3:0]       dec_be_n;
  logic             mid_hit;
  logic [BR_W-1:0]  mid_idx;
  logic             access_ok;
  logic             is_io;
  logic [OFS_W-1:0] ofs;
  logic [PCI_W-1:0] addr_next;

  sx_ext_reg #(.W(EXT_W)) u_ext (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ext_wr_en),
    .wr_data (ext_wr_data),
    .q       (ext_q)
  );

  sx_lane_decode u_lane (
    .len   (req_addr[4:3]),
    .off   (req_addr[6:5]),
    .legal (dec_legal),
    .be_n  (dec_be_n)
  );

  sx_bridge_sel #(
    .MID_W    (MID_W),
    .N_BRIDGE (N_BRIDGE),
    .MID_BASE (MID_BASE)
  ) u_br (
    .mid (req_addr[MID_LSB +: MID_W]),
    .hit (mid_hit),
    .idx (mid_idx)
  );

  assign access_ok = dec_legal && mid_hit;
  assign is_io     = req_addr[IO_BIT];
  assign ofs       = req_addr[OFS_LSB +: OFS_W];
  assign addr_next = is_io ? {{IOPAD_W{1'b0}}, ofs, 2'b00}
                           : {ext_q, {PAD_W{1'b0}}, ofs, 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pci_valid  <= 1'b0;
      bad_access <= 1'b0;
      pci_addr   <= '0;
      pci_be_n   <= 4'hF;
      pci_size   <= 2'd0;
      pci_bridge <= '0;
      pci_is_io  <= 1'b0;
    end else begin
      pci_valid  <= req_valid && access_ok;
      bad_access <= req_valid && !access_ok;
      if (req_valid && access_ok) begin
        pci_addr   <= addr_next;
        pci_be_n   <= dec_be_n;
        pci_size   <= req_addr[4:3];
        pci_bridge <= mid_idx;
        pci_is_io  <= is_io;
      end
    end
  end

endmodule

// File: rtl/sparse_xlate_chk.sv
module sparse_xlate_chk #(
  parameter int PCI_W = 32,
  parameter int EXT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             ext_wr_en,
  input logic [EXT_W-1:0] ext_wr_data,
  input logic [EXT_W-1:0] ext_q,
  input logic             dec_legal,
  input logic             mid_hit,
  input logic             pci_valid,
  input logic [PCI_W-1:0] pci_addr,
  input logic [3:0]       pci_be_n,
  input logic [1:0]       pci_size,
  input logic             pci_is_io,
  input logic             bad_access
);
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pci_valid && bad_access));

  a_r6_reject: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !(dec_legal && mid_hit) |=> bad_access && !pci_valid);

  a_r13_answer: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> pci_valid || bad_access);

  a_r13_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !pci_valid && !bad_access);

  a_r8_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    pci_valid |-> pci_addr[1:0] == 2'b00);

  a_r7_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
    pci_valid |-> $countones(~pci_be_n) == int'(pci_size) + 1);

  a_r10_io_upper: assert property (@(posedge clk) disable iff (!rst_n)
    pci_valid && pci_is_io |-> pci_addr[PCI_W-1 -: 6] == 6'd0);

  a_r12_load: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr_en |=> ext_q == $past(ext_wr_data));

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_wr_en |=> $stable(ext_q));
endmodule

bind sparse_xlate sparse_xlate_chk #(.PCI_W(PCI_W), .EXT_W(EXT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .ext_wr_en   (ext_wr_en),
  .ext_wr_data (ext_wr_data),
  .ext_q       (ext_q),
  .dec_legal   (dec_legal),
  .mid_hit     (mid_hit),
  .pci_valid   (pci_valid),
  .pci_addr    (pci_addr),
  .pci_be_n    (pci_be_n),
  .pci_size    (pci_size),
  .pci_is_io   (pci_is_io),
  .bad_access  (bad_access)
);

// File: tb/sparse_xlate_tb_top.sv
module sparse_xlate_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic        ext_wr_en = 1'b0;
  logic [2:0]  ext_wr_data = '0;
  logic        pci_valid;
  logic [31:0] pci_addr;
  logic [3:0]  pci_be_n;
  logic [1:0]  pci_size;
  logic [1:0]  pci_bridge;
  logic        pci_is_io;
  logic        bad_access;

  always #2 clk = ~clk;  // 250 MHz

  sparse_xlate dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .ext_wr_en   (ext_wr_en),
    .ext_wr_data (ext_wr_data),
    .pci_valid   (pci_valid),
    .pci_addr    (pci_addr),
    .pci_be_n    (pci_be_n),
    .pci_size    (pci_size),
    .pci_bridge  (pci_bridge),
    .pci_is_io   (pci_is_io),
    .bad_access  (bad_access)
  );

  typedef struct {
    logic        ok;
    logic [31:0] addr;
    logic [3:0]  be_n;
    logic [1:0]  size;
    logic [1:0]  bridge;
    logic        io;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          checks = 0;
  int          failures = 0;
  logic [2:0]  ext_model = 3'd0;
  bit          mon_on = 1'b0;
  bit          finished = 1'b0;

  function automatic logic [63:0] mk(input int mid, input bit io,
                                     input logic [23:0] ofs,
                                     input int off, input int len);
    logic [63:0] a = '0;
    a[35:33] = 3'(mid);
    a[31]    = io;
    a[30:7]  = ofs;
    a[6:5]   = 2'(off);
    a[4:3]   = 2'(len);
    a[2:0]   = 3'b101;  // ignored low bits
    return a;
  endfunction

  // Expected lanes, written as sets of taking-part lanes (1 = active).
  function automatic bit exp_lanes(input int len, input int off, output logic [3:0] be_n);
    logic [3:0] act = 4'b0000;
    bit ok = 1'b0;
    case (len)
      0: begin ok = 1'b1; act[off] = 1'b1; end
      1: if (off == 0 || off == 2) begin ok = 1'b1; act[off] = 1'b1; act[off+1] = 1'b1; end
      2: if (off <= 1) begin ok = 1'b1; act = (off == 0) ? 4'b0111 : 4'b1110; end
      3: if (off == 2) begin ok = 1'b1; act = 4'b1111; end
      default: ok = 1'b0;
    endcase
    be_n = ~act;
    return ok;
  endfunction

  task automatic fail(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    failures++;
    $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
  endtask

  task automatic access(input logic [63:0] a, input bit we, input logic [2:0] wd, input string tag);
    exp_t e;
    logic [3:0] be;
    bit lane_ok;
    int len = int'(a[4:3]);
    int off = int'(a[6:5]);
    @(negedge clk);
    req_valid   = 1'b1;
    req_addr    = a;
    ext_wr_en   = we;
    ext_wr_data = wd;
    lane_ok  = exp_lanes(len, off, be);
    e.ok     = lane_ok && (a[35:33] >= 3'd4);
    e.be_n   = be;
    e.size   = a[4:3];
    e.bridge = 2'(int'(a[35:33]) - 4);
    e.io     = a[31];
    e.addr   = a[31] ? {6'd0, a[30:7], 2'b00} : {ext_model, 3'd0, a[30:7], 2'b00};
    e.tag    = tag;
    sb_q.push_back(e);
    if (we) ext_model = wd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      ext_wr_en = 1'b0;
    end
  endtask

  task automatic ext_write(input logic [2:0] wd);
    @(negedge clk);
    req_valid   = 1'b0;
    ext_wr_en   = 1'b1;
    ext_wr_data = wd;
    ext_model   = wd;
  endtask

  // Monitor: one result cycle per request, on the following edge.
  initial begin
    exp_t e;
    wait (mon_on);
    forever begin
      @(posedge clk);
      #1;
      checks++;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        if (pci_valid !== e.ok || bad_access !== !e.ok)
          fail(e.tag, "valid/reject", {pci_valid, bad_access}, {e.ok, !e.ok});
        else if (e.ok) begin
          if (pci_be_n !== e.be_n)     fail(e.tag, "be_n", pci_be_n, e.be_n);
          if (pci_size !== e.size)     fail(e.tag, "size", pci_size, e.size);
          if (pci_addr !== e.addr)     fail(e.tag, "addr", pci_addr, e.addr);
          if (pci_bridge !== e.bridge) fail(e.tag, "bridge", pci_bridge, e.bridge);
          if (pci_is_io !== e.io)      fail(e.tag, "is_io", pci_is_io, e.io);
        end
      end else if (pci_valid !== 1'b0 || bad_access !== 1'b0) begin
        fail("R13", "output without request", {pci_valid, bad_access}, 0);
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    string t;
    repeat (4) @(negedge clk);
    checks++;
    if (pci_valid !== 1'b0 || bad_access !== 1'b0)
      fail("R1", "outputs in reset", {pci_valid, bad_access}, 0);
    rst_n = 1'b1;
    mon_on = 1'b1;

    // R1: extension register starts at zero.
    access(mk(4, 0, 24'hABCDEF, 0, 0), 0, 3'd0, "R1");

    // R2..R5, R7: every length/offset pair.
    for (int len = 0; len < 4; len++) begin
      for (int off = 0; off < 4; off++) begin
        t = (len == 0) ? "R2" : (len == 1) ? "R3" : (len == 2) ? "R4" : "R5";
        access(mk(4, 0, 24'h000100, off, len), 0, 3'd0, t);
      end
    end
    idle(2);

    // R6: illegal back-to-back with legal.
    access(mk(5, 0, 24'h123456, 1, 1), 0, 3'd0, "R6");
    access(mk(5, 0, 24'h123456, 0, 1), 0, 3'd0, "R6");
    access(mk(5, 0, 24'h123456, 3, 3), 0, 3'd0, "R6");
    idle(1);

    // R8: offset field patterns.
    access(mk(4, 0, 24'h000000, 2, 3), 0, 3'd0, "R8");
    access(mk(4, 0, 24'hFFFFFF, 2, 3), 0, 3'd0, "R8");
    access(mk(4, 0, 24'hAAAAAA, 1, 0), 0, 3'd0, "R8");
    access(mk(4, 0, 24'h555555, 3, 0), 0, 3'd0, "R8");

    // R11: all module ids.
    for (int m = 0; m < 8; m++) access(mk(m, 0, 24'h0F0F0F, 0, 0), 0, 3'd0, "R11");
    idle(1);

    // R12: write in the same cycle as an access, then later accesses.
    access(mk(4, 0, 24'h000010, 2, 3), 1, 3'd5, "R12");
    access(mk(4, 0, 24'h000010, 2, 3), 0, 3'd0, "R12");
    ext_write(3'd7);
    access(mk(6, 0, 24'h7FFFFF, 0, 1), 0, 3'd0, "R9");
    access(mk(6, 1, 24'h7FFFFF, 2, 1), 0, 3'd0, "R10");
    access(mk(7, 1, 24'hFFFFFF, 0, 2), 1, 3'd2, "R10");
    access(mk(7, 0, 24'h000001, 1, 2), 0, 3'd0, "R9");
    idle(3);

    // R13: idle cycles are checked by the monitor for silence.
    idle(4);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule